// File: doc/BRIEF.md
# Programmable Clock Channel Divider

This block divides an incoming clock by a programmable ratio. The high time and the low time of the output are set separately. A 4-bit high field `hi_cnt` gives a high time of `hi_cnt`+1 input cycles, and a 4-bit low field `lo_cnt` gives a low time of `lo_cnt`+1 input cycles. The output period is therefore `hi_cnt`+`lo_cnt`+2 input cycles, and the uncorrected duty cycle is (`hi_cnt`+1)/(`hi_cnt`+`lo_cnt`+2).

Each divider can be aligned with its neighbours through a resynchronisation pulse. The pulse parks the output at a chosen start level. It also loads a coarse delay, counted in input rising edges, which runs before the high/low pattern starts after release. The start level and the delay are captured only on that pulse. New high and low counts are taken only when a full period ends, so a change never produces a runt pulse.

Two more modes act on the output:
- A pass-through mode sends the input clock straight to the output.
- A duty-fix mode makes odd ratios 50%. It stretches the high time by half an input period, using a register clocked on the falling edge. A setting that cannot be corrected raises a flag and leaves the waveform uncorrected.

Top module: `clkdiv_chan`

## Requirements
- R1: While `rst` is high, `clk_out` is low one edge after `rst` is sampled, and `cfg_bad` is low.
- R2: Once the pattern runs with fixed settings, `clk_out` is high for `hi_cnt`+1 input cycles and low for `lo_cnt`+1 input cycles, in turn.
- R3: At each rising edge where `resync` is sampled high, `clk_out` is set to the value of `start_hi`, and it stays there while `resync` remains high.
- R4: After `resync` is released, `clk_out` keeps the start level for `ofs_cnt` input cycles, counted from the first rising edge that samples `resync` low. The pattern then begins.
- R5: With `start_hi`=1 the pattern begins with the high phase. With `start_hi`=0 it begins with a low phase of `lo_cnt`+1 cycles, so the first rise comes `ofs_cnt`+`lo_cnt`+1 cycles after release.
- R6: Changes to `ofs_cnt` or `start_hi` while `resync` is low do not alter `clk_out`.
- R7: New `hi_cnt` and `lo_cnt` values are captured only at the edge that ends a low phase, and they apply from the following high phase. The phase in progress, and the low phase of the first period, keep the previous values.
- R8: With `pass_thru`=1, `clk_out` equals `clk_in`.
- R9: With `duty_fix`=1 and `lo_cnt`=`hi_cnt`+1, `clk_out` stays high through the first half of the input cycle that follows each high phase. This gives a 50% duty cycle.
- R10: With `duty_fix`=1 and `lo_cnt`=`hi_cnt`, the waveform is the uncorrected one and `cfg_bad` stays low.
- R11: With `duty_fix`=1 and `lo_cnt` equal to neither `hi_cnt` nor `hi_cnt`+1, `cfg_bad` is high and the waveform is the uncorrected one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to divide |
| rst | input | 1 | Synchronous active-high reset |
| resync | input | 1 | Realign pulse; captures start level and delay |
| pass_thru | input | 1 | Route `clk_in` directly to `clk_out` |
| duty_fix | input | 1 | Enable half-cycle duty correction |
| hi_cnt | input | 4 | High time minus one, in input cycles |
| lo_cnt | input | 4 | Low time minus one, in input cycles |
| ofs_cnt | input | 4 | Coarse delay after release, in input cycles |
| start_hi | input | 1 | Start level and first phase selection |
| clk_out | output | 1 | Divided clock |
| cfg_bad | output | 1 | Duty-fix requested with an invalid count pair |

## Verification
A corrupted down-counter or phase state shows on `clk_out` within one output period, as a phase that is too long or too short. Since every cycle is compared against a computed level, the first wrong edge is caught. A lost or stale start level or delay appears in the first cycles after `resync` is released, before any rise. A stale or early copy of the high and low counts shows only at the first period boundary after an input change. For this reason the change tests run for several periods. A wrong falling-edge copy appears only in the first half-cycle after a high phase ends, so the bench samples both halves of every cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_WAIT = 2'd1,
    PH_HIGH = 2'd2,
    PH_LOW  = 2'd3
  } ph_e;
endpackage

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         resync,
  input  logic         start_hi,
  input  logic [W-1:0] hi_cnt,
  input  logic [W-1:0] lo_cnt,
  input  logic [W-1:0] ofs_cnt,
  output logic         hi_q,
  output logic [W-1:0] n_cur,
  output logic [W-1:0] m_cur
);
  ph_e          st;
  logic [W-1:0] cnt;
  logic [W-1:0] po_l;
  logic         sh_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= PH_HOLD;
      cnt   <= '0;
      po_l  <= '0;
      sh_l  <= 1'b0;
      hi_q  <= 1'b0;
      n_cur <= hi_cnt;
      m_cur <= lo_cnt;
    end else if (resync) begin
      // park at the start level and capture alignment settings
      st    <= PH_HOLD;
      cnt   <= '0;
      po_l  <= ofs_cnt;
      sh_l  <= start_hi;
      hi_q  <= start_hi;
      n_cur <= hi_cnt;
      m_cur <= lo_cnt;
    end else begin
      unique case (st)
        PH_HOLD: begin
          hi_q <= sh_l;
          if (po_l == '0) begin
            st  <= sh_l ? PH_HIGH : PH_LOW;
            cnt <= sh_l ? n_cur : m_cur;
          end else begin
            st  <= PH_WAIT;
            cnt <= po_l - 1'b1;
          end
        end
        PH_WAIT: begin
          if (cnt == '0) begin
            st   <= sh_l ? PH_HIGH : PH_LOW;
            cnt  <= sh_l ? n_cur : m_cur;
            hi_q <= sh_l;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt == '0) begin
            st   <= PH_LOW;
            cnt  <= m_cur;
            hi_q <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt == '0) begin
            // period boundary: take new counts here only
            st    <= PH_HIGH;
            n_cur <= hi_cnt;
            m_cur <= lo_cnt;
            cnt   <= hi_cnt;
            hi_q  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= PH_HOLD;
      endcase
    end
  end

  assert_hold_level_R3: assert property (@(posedge clk) disable iff (rst)
    resync |=> (hi_q == $past(start_hi)));

  assert_high_run_R2: assert property (@(posedge clk) disable iff (rst)
    (st == PH_HIGH && cnt != '0 && !resync) |=> (hi_q && st == PH_HIGH));

  assert_low_run_R2: assert property (@(posedge clk) disable iff (rst)
    (st == PH_LOW && cnt != '0 && !resync) |=> (!hi_q && st == PH_LOW));

  assert_wait_level_R4: assert property (@(posedge clk) disable iff (rst)
    (st == PH_WAIT && !resync) |=> $stable(hi_q));

  assert_counts_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (st == PH_HIGH && !resync) |=> ($stable(n_cur) && $stable(m_cur)));
endmodule

// File: rtl/clkdiv_cfgchk.sv
module clkdiv_cfgchk #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         duty_fix,
  input  logic [W-1:0] n_cur,
  input  logic [W-1:0] m_cur,
  output logic         fix_act,
  output logic         cfg_bad
);
  localparam int EW = W + 1;

  logic [EW-1:0] n_ext, m_ext;
  logic          odd_ok, even_ok;

  always_comb begin
    n_ext   = {1'b0, n_cur};
    m_ext   = {1'b0, m_cur};
    odd_ok  = (m_ext == n_ext + 1'b1);
    even_ok = (m_ext == n_ext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_act <= 1'b0;
      cfg_bad <= 1'b0;
    end else begin
      fix_act <= duty_fix & odd_ok;
      cfg_bad <= duty_fix & ~(odd_ok | even_ok);
    end
  end
endmodule

// File: rtl/clkdiv_duty.sv
module clkdiv_duty (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic q,
  output logic q_out
);
  logic qn;

  // falling-edge copy trails the divider output by half a cycle
  always_ff @(negedge clk) begin
    if (rst) qn <= 1'b0;
    else     qn <= q;
  end

  assign q_out = q | (act & qn);
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
  import clkdiv_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_in,
  input  logic         rst,
  input  logic         resync,
  input  logic         pass_thru,
  input  logic         duty_fix,
  input  logic [W-1:0] hi_cnt,
  input  logic [W-1:0] lo_cnt,
  input  logic [W-1:0] ofs_cnt,
  input  logic         start_hi,
  output logic         clk_out,
  output logic         cfg_bad
);
  logic         div_q;
  logic         div_o;
  logic         fix_act;
  logic [W-1:0] n_cur, m_cur;

  clkdiv_seq #(.W(W)) seq_i (
    .clk      (clk_in),
    .rst      (rst),
    .resync   (resync),
    .start_hi (start_hi),
    .hi_cnt   (hi_cnt),
    .lo_cnt   (lo_cnt),
    .ofs_cnt  (ofs_cnt),
    .hi_q     (div_q),
    .n_cur    (n_cur),
    .m_cur    (m_cur)
  );

  clkdiv_cfgchk #(.W(W)) chk_i (
    .clk      (clk_in),
    .rst      (rst),
    .duty_fix (duty_fix),
    .n_cur    (n_cur),
    .m_cur    (m_cur),
    .fix_act  (fix_act),
    .cfg_bad  (cfg_bad)
  );

  clkdiv_duty duty_i (
    .clk   (clk_in),
    .rst   (rst),
    .act   (fix_act),
    .q     (div_q),
    .q_out (div_o)
  );

  assign clk_out = pass_thru ? clk_in : div_o;

  assert_bad_no_stretch_R11: assert property (@(posedge clk_in) disable iff (rst)
    (cfg_bad && !pass_thru && !div_q) |-> !clk_out);
endmodule

// File: tb/clkdiv_chan_tb.sv
module clkdiv_chan_tb_top;
  logic       clk_in = 1'b0;
  logic       rst = 1'b1;
  logic       resync = 1'b0;
  logic       pass_thru = 1'b0;
  logic       duty_fix = 1'b0;
  logic [3:0] hi_cnt = '0;
  logic [3:0] lo_cnt = '0;
  logic [3:0] ofs_cnt = '0;
  logic       start_hi = 1'b0;
  logic       clk_out;
  logic       cfg_bad;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit lvl;
    bit dcc;
    bit skip1;
    int req;
  } exp_t;

  exp_t sbq[$];

  clkdiv_chan #(.W(4)) dut_i (
    .clk_in    (clk_in),
    .rst       (rst),
    .resync    (resync),
    .pass_thru (pass_thru),
    .duty_fix  (duty_fix),
    .hi_cnt    (hi_cnt),
    .lo_cnt    (lo_cnt),
    .ofs_cnt   (ofs_cnt),
    .start_hi  (start_hi),
    .clk_out   (clk_out),
    .cfg_bad   (cfg_bad)
  );

  always #4 clk_in = ~clk_in;

  task automatic chk(input bit ok, input int req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // monitor: pops one expected level per input cycle, samples both halves
  bit prev_lvl = 0;
  always begin
    @(posedge clk_in);
    #2;
    if (sbq.size() > 0) begin
      exp_t it;
      bit e1;
      it = sbq.pop_front();
      e1 = it.lvl | (it.dcc & prev_lvl);
      if (!it.skip1) chk(clk_out == e1, it.req, clk_out, e1);
      #4;
      chk(clk_out == it.lvl, it.req, clk_out, it.lvl);
      prev_lvl = it.lvl;
    end
  end

  // driver: programs a resync, then pushes the level each cycle should show
  task automatic run(input bit sh, input int po, input int n0, input int m0,
                     input int n1, input int m1, input bit dcc, input bit poke,
                     input int cyc, input int req);
    bit cur;
    bit lvl;
    int rem;
    int pstart;
    bit dcc_eff;
    dcc_eff = dcc && (m0 == n0 + 1);
    @(posedge clk_in); #1;
    hi_cnt = 4'(n0); lo_cnt = 4'(m0); ofs_cnt = 4'(po);
    start_hi = sh; duty_fix = dcc; resync = 1'b1;
    @(posedge clk_in); #1;
    sbq.push_back('{lvl: sh, dcc: dcc_eff, skip1: 1'b1, req: 3}); // R3 hold level
    resync = 1'b0;
    cur = sh; rem = 0; pstart = 0;
    for (int k = 0; k < cyc; k++) begin
      @(posedge clk_in); #1;
      if (k == po) begin hi_cnt = 4'(n1); lo_cnt = 4'(m1); end
      if (poke && k == po + 1) begin ofs_cnt = 4'(po + 7); start_hi = !sh; end // R6
      if (k < po) begin
        sbq.push_back('{lvl: sh, dcc: dcc_eff, skip1: 1'b0, req: 4}); // R4 delay
      end else begin
        if (k == po) begin
          cur = sh;
          rem = sh ? n0 + 1 : m0 + 1;
          pstart = sh ? 1 : 0;
        end
        lvl = cur;
        rem--;
        if (rem == 0) begin
          if (cur) begin
            cur = 0;
            rem = (pstart == 1 && sh) ? m0 + 1 : m1 + 1;
          end else begin
            cur = 1;
            pstart++;
            rem = n1 + 1;
          end
        end
        sbq.push_back('{lvl: lvl, dcc: dcc_eff, skip1: 1'b0, req: req});
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(posedge clk_in); @(posedge clk_in); #2;
    chk(clk_out == 1'b0, 1, clk_out, 0);
    chk(cfg_bad == 1'b0, 1, cfg_bad, 0);
    rst = 1'b0;

    run(1, 0, 3, 2, 3, 2, 0, 0, 30, 2);   // R2 high-first pattern
    run(0, 0, 1, 4, 1, 4, 0, 0, 24, 5);   // R5 low phase first
    run(1, 5, 2, 2, 2, 2, 0, 0, 24, 4);   // R4 delay with high start
    run(0, 3, 0, 0, 0, 0, 0, 0, 16, 5);   // R5 delay plus low start, ratio 2
    run(0, 2, 2, 1, 2, 1, 0, 1, 24, 6);   // R6 offset/start changes ignored
    run(1, 1, 3, 2, 1, 5, 0, 0, 36, 7);   // R7 counts change at boundary
    run(0, 0, 4, 2, 0, 3, 0, 0, 30, 7);   // R7 change with low start
    run(1, 0, 2, 3, 2, 3, 1, 0, 28, 9);   // R9 ratio 7 corrected
    run(0, 1, 0, 1, 0, 1, 1, 0, 15, 9);   // R9 ratio 3 corrected
    run(1, 0, 3, 3, 3, 3, 1, 0, 24, 10);  // R10 even ratio unchanged
    chk(cfg_bad == 1'b0, 10, cfg_bad, 0);
    run(1, 0, 1, 4, 1, 4, 1, 0, 21, 11);  // R11 invalid pair, uncorrected
    chk(cfg_bad == 1'b1, 11, cfg_bad, 1);

    // R8 pass-through
    @(posedge clk_in); #1;
    duty_fix = 1'b0;
    pass_thru = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk_in); #2;
      chk(clk_out == 1'b1, 8, clk_out, 1);
      #4;
      chk(clk_out == 1'b0, 8, clk_out, 0);
    end
    pass_thru = 1'b0;

    repeat (3) @(posedge clk_in);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule